// File: doc/BRIEF.md
# DRAM Bank Size Detection Engine

At startup this engine finds how much memory each of eight DRAM banks holds. It needs no help from a processor. It drives a simple read/write master port. First it places every bank base on its own fixed 128 MiB boundary through a configuration write port. It then probes the banks one at a time. A 64-bit signature goes into the last 8 bytes of a 64 MiB probe window. The engine then reads the last 8 bytes of each successive 1 MiB step, starting from the bottom of the bank. The first step that returns the signature marks the size. This works because a bank smaller than the window aliases the top-of-window write into its own final 8 bytes.

Each bank's result goes out through a table write port, in bank order. The result holds a base address, which is the packed running total of the sizes found so far, and a size in MiB. A bank that never returns the signature is flagged for a slower fallback search, which lies outside this block, and it is reported with size zero. A done pulse ends the run. A new start pulse runs the sequence again.

Top module: `bank_sizer`

## Requirements
- R1: After reset the engine is idle: mem_req, cfg_we, res_we and done are all low.
- R2: On start, before any memory access, the engine issues eight base writes, one per cycle. They run from index 7 down to index 0, and each base is index × 128 MiB.
- R3: The first memory access for bank b is a write of the signature 64'h5A17_C0DE_9E3B_44F1 to address b × 128 MiB + 64 MiB − 8.
- R4: After that write, the engine reads address b × 128 MiB + (k+1) MiB − 8 for k = 0, 1, 2 and so on, in ascending order. It waits for mem_rvalid before it compares, and it stops at the first read that returns the signature.
- R5: A match at step k reports a size of k+1 MiB, with res_size counted in MiB units. A bank of 64 MiB or more reports 64.
- R6: If none of the 64 reads matches, the bank is reported with res_fallback = 1 and res_size = 0.
- R7: Results are written in bank order 0 to 7. Bank 0's res_base is 0, and each later base is the byte sum of the sizes reported before it, so a zero-size bank does not advance it.
- R8: A memory request holds mem_req, mem_we and mem_addr unchanged until the cycle in which mem_ready is high.
- R9: done is a single-cycle pulse that follows the eighth result. A start pulse during a run has no effect. A start pulse after done starts a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a detection run when the engine is idle |
| cfg_we | output | 1 | Strobe for a bank base write |
| cfg_idx | output | 3 | Index of the bank base being written |
| cfg_base | output | 32 | Byte address written to that bank base |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 8-byte access |
| mem_wdata | output | 64 | Write data (the signature) |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| res_we | output | 1 | Strobe for a result table write |
| res_idx | output | 3 | Bank index of the result |
| res_base | output | 32 | Packed base address of the bank in bytes |
| res_size | output | 7 | Detected size in MiB (0 to 64) |
| res_fallback | output | 1 | No alias was found, so the fallback search is needed |
| done | output | 1 | Single-cycle pulse when all banks are processed |

## Verification
A wrong step counter moves the read address off the (k+1) MiB − 8 pattern on the very next read request. A wrong bank counter puts the signature write in the wrong 128 MiB slot. Either fault therefore shows up within one memory transaction. A corrupted running base or size register shows up only at the next res_we strobe, so the bench compares every table entry with sums it computes from the bank sizes it placed in its memory model. Handshake faults appear as address changes during stalled cycles, which the bench exposes by holding mem_ready low on some cycles.

// File: rtl/bank_sizer.sv
module bank_sizer #(
  parameter int NBANK   = 8,
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int SLOT_SH = 27,
  parameter int STEP_SH = 20,
  parameter int WIN_MB  = 64,
  parameter logic [DW-1:0] SIG = 64'h5A17_C0DE_9E3B_44F1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         cfg_we,
  output logic [$clog2(NBANK)-1:0]     cfg_idx,
  output logic [AW-1:0]                cfg_base,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [DW-1:0]                mem_wdata,
  input  logic                         mem_ready,
  input  logic                         mem_rvalid,
  input  logic [DW-1:0]                mem_rdata,
  output logic                         res_we,
  output logic [$clog2(NBANK)-1:0]     res_idx,
  output logic [AW-1:0]                res_base,
  output logic [$clog2(WIN_MB+1)-1:0]  res_size,
  output logic                         res_fallback,
  output logic                         done
);
  localparam int IW  = $clog2(NBANK);
  localparam int KW  = $clog2(WIN_MB);
  localparam int SZW = $clog2(WIN_MB+1);

  typedef enum logic [2:0] {S_IDLE, S_CFG, S_WR, S_RD, S_WAIT, S_REC, S_DONE} st_t;
  st_t st;

  logic [IW-1:0]  bank, cfg_cnt;
  logic [KW-1:0]  k;
  logic [SZW-1:0] size_q;
  logic           fb_q;
  logic [AW-1:0]  acc;

  wire [AW-1:0] bank_base = AW'(bank) << SLOT_SH;
  wire [AW-1:0] win_top   = bank_base + (AW'(WIN_MB) << STEP_SH) - AW'(8);
  wire [AW-1:0] rd_addr   = bank_base + ((AW'(k) + AW'(1)) << STEP_SH) - AW'(8);

  assign cfg_we       = (st == S_CFG);
  assign cfg_idx      = cfg_cnt;
  assign cfg_base     = AW'(cfg_cnt) << SLOT_SH;
  assign mem_req      = (st == S_WR) || (st == S_RD);
  assign mem_we       = (st == S_WR);
  assign mem_addr     = mem_we ? win_top : rd_addr;
  assign mem_wdata    = SIG;
  assign res_we       = (st == S_REC);
  assign res_idx      = bank;
  assign res_base     = acc;
  assign res_size     = size_q;
  assign res_fallback = fb_q;
  assign done         = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bank    <= '0;
      cfg_cnt <= '0;
      k       <= '0;
      size_q  <= '0;
      fb_q    <= 1'b0;
      acc     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          cfg_cnt <= IW'(NBANK-1);
          st      <= S_CFG;
        end
        S_CFG: if (cfg_cnt == '0) begin
          bank <= '0;
          acc  <= '0;
          st   <= S_WR;
        end else begin
          cfg_cnt <= cfg_cnt - 1'b1;
        end
        S_WR: if (mem_ready) begin
          k  <= '0;
          st <= S_RD;
        end
        S_RD: if (mem_ready) st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (mem_rdata == SIG) begin
            size_q <= SZW'(k) + SZW'(1);
            fb_q   <= 1'b0;
            st     <= S_REC;
          end else if (k == KW'(WIN_MB-1)) begin
            size_q <= '0;
            fb_q   <= 1'b1;
            st     <= S_REC;
          end else begin
            k  <= k + 1'b1;
            st <= S_RD;
          end
        end
        S_REC: begin
          acc <= acc + (AW'(size_q) << STEP_SH);
          if (bank == IW'(NBANK-1)) st <= S_DONE;
          else begin
            bank <= bank + 1'b1;
            st   <= S_WR;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r2_cfg_before_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !mem_req && !res_we);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_we) && $past(res_idx) == IW'(NBANK-1));

  a_r6_fallback_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_we && res_fallback |-> res_size == '0);

  a_r5_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_size <= SZW'(WIN_MB));
endmodule

// File: tb/bank_sizer_bench.sv
module bank_sizer_bench;
  localparam longint MIB  = 64'd1 << 20;
  localparam longint SLOT = 64'd1 << 27;
  localparam logic [63:0] SIG = 64'h5A17_C0DE_9E3B_44F1;

  logic clk = 0, rst_n = 0, start = 0;
  logic cfg_we; logic [2:0] cfg_idx; logic [31:0] cfg_base;
  logic mem_req, mem_we; logic [31:0] mem_addr; logic [63:0] mem_wdata;
  logic mem_ready = 0, mem_rvalid = 0; logic [63:0] mem_rdata = '0;
  logic res_we; logic [2:0] res_idx; logic [31:0] res_base; logic [6:0] res_size;
  logic res_fallback, done;

  always #10 clk = ~clk;

  bank_sizer u_bank_sizer (.*);

  int n_chk = 0, n_fail = 0;
  bit aborted = 0;
  int cyc = 0;
  int rdy_mode = 0;

  int sz [8];
  bit     st_v [8];
  longint st_off [8];
  logic [63:0] st_dat [8];

  int cfg_n; int cfg_i_log [8]; longint cfg_b_log [8]; bit cfg_late; bit mem_seen;
  int rec_n; int rec_i [8]; longint rec_b [8]; int rec_s [8]; bit rec_f [8];
  int wr_n [8]; longint wr_a [8]; logic [63:0] wr_d [8]; bit wr_order_err;
  int rd_n [8]; int rd_err;
  int hs_err; int done_n; bit done_bad;

  bit pend; bit pend_we; logic [31:0] pend_addr; logic [63:0] pend_dat;
  bit stall; logic [31:0] stall_addr; bit stall_we;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    cfg_n = 0; cfg_late = 0; mem_seen = 0; rec_n = 0; rd_err = 0; hs_err = 0;
    done_n = 0; done_bad = 0; wr_order_err = 0;
    for (int i = 0; i < 8; i++) begin
      wr_n[i] = 0; rd_n[i] = 0; st_v[i] = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (stall && !(mem_req && stall_addr == mem_addr && stall_we == mem_we)) hs_err++;
    mem_rvalid <= 1'b0;
    if (pend) begin
      int b; longint off, eff;
      b = int'(pend_addr[29:27]);
      off = longint'(pend_addr[26:0]);
      eff = (sz[b] == 0) ? -1 : off % (longint'(sz[b]) * MIB);
      if (pend_we) begin
        if (wr_n[b] == 0) begin wr_a[b] = longint'(pend_addr); wr_d[b] = pend_dat; end
        if (rd_n[b] != 0) wr_order_err = 1;
        wr_n[b]++;
        if (sz[b] != 0) begin st_v[b] = 1; st_off[b] = eff; st_dat[b] = pend_dat; end
      end else begin
        if (wr_n[b] == 0) wr_order_err = 1;
        if (longint'(pend_addr) != longint'(b) * SLOT + longint'(rd_n[b] + 1) * MIB - 8) rd_err++;
        rd_n[b]++;
        mem_rvalid <= 1'b1;
        mem_rdata  <= (st_v[b] && eff == st_off[b]) ? st_dat[b] : {32'hDEAD_0000, pend_addr};
      end
    end
    if (cfg_we) begin
      if (mem_seen) cfg_late = 1;
      if (cfg_n < 8) begin cfg_i_log[cfg_n] = int'(cfg_idx); cfg_b_log[cfg_n] = longint'(cfg_base); end
      cfg_n++;
    end
    if (res_we) begin
      if (rec_n < 8) begin
        rec_i[rec_n] = int'(res_idx); rec_b[rec_n] = longint'(res_base);
        rec_s[rec_n] = int'(res_size); rec_f[rec_n] = res_fallback;
      end
      rec_n++;
    end
    if (done) begin
      done_n++;
      if (rec_n != 8) done_bad = 1;
    end
    begin
      logic r;
      r = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
      mem_ready <= r;
      if (mem_req) mem_seen = 1;
      pend = mem_req && r;
      pend_we = mem_we; pend_addr = mem_addr; pend_dat = mem_wdata;
      stall = mem_req && !r; stall_addr = mem_addr; stall_we = mem_we;
    end
  end

  task automatic run_case(input string name, input int s0, input int s1, input int s2, input int s3,
                          input int s4, input int s5, input int s6, input int s7,
                          input int mode, input bit poke_start);
    int lim; longint acc; int e;
    if (aborted) return;
    sz[0]=s0; sz[1]=s1; sz[2]=s2; sz[3]=s3; sz[4]=s4; sz[5]=s5; sz[6]=s6; sz[7]=s7;
    rdy_mode = mode;
    @(negedge clk); clear_mon();
    start = 1; @(negedge clk); start = 0;
    lim = 0;
    while (done_n == 0 && lim < 40000) begin
      @(negedge clk); lim++;
      if (poke_start && lim == 200) start = 1;
      if (poke_start && lim == 201) start = 0;
    end
    if (done_n == 0) begin
      chk(0, "R9", {name, " watchdog expired"}, 0, 1);
      aborted = 1; return;
    end
    repeat (6) @(negedge clk);
    $display("case %s", name);
    chk(cfg_n == 8, "R2", "base write count", cfg_n, 8);
    e = 0;
    for (int i = 0; i < 8; i++)
      if (cfg_i_log[i] != 7 - i || cfg_b_log[i] != longint'(7 - i) * SLOT) e++;
    chk(e == 0 && !cfg_late, "R2", "base write order/value errors", e + int'(cfg_late), 0);
    e = 0;
    for (int i = 0; i < 8; i++)
      if (wr_n[i] != 1 || wr_a[i] != longint'(i) * SLOT + 64 * MIB - 8 || wr_d[i] != SIG) e++;
    chk(e == 0 && !wr_order_err, "R3", "signature write errors", e, 0);
    chk(rd_err == 0, "R4", "read address sequence errors", rd_err, 0);
    e = 0;
    for (int i = 0; i < 8; i++) begin
      int exp_n;
      exp_n = (sz[i] == 0) ? 64 : (sz[i] > 64 ? 64 : sz[i]);
      if (rd_n[i] != exp_n) e++;
    end
    chk(e == 0, "R4", "banks with wrong read count", e, 0);
    chk(rec_n == 8, "R7", "result count", rec_n, 8);
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      int es; bit ef;
      es = (sz[i] > 64) ? 64 : sz[i];
      ef = (sz[i] == 0);
      chk(rec_i[i] == i, "R7", "result index", rec_i[i], i);
      chk(rec_b[i] == acc, "R7", "result base", rec_b[i], acc);
      chk(rec_s[i] == es, ef ? "R6" : "R5", "result size", rec_s[i], es);
      chk(rec_f[i] == ef, "R6", "fallback flag", int'(rec_f[i]), int'(ef));
      acc += longint'(es) * MIB;
    end
    chk(done_n == 1 && !done_bad, "R9", "done pulses", done_n, 1);
    chk(hs_err == 0, "R8", "handshake hold violations", hs_err, 0);
  endtask

  task automatic test_reset();
    #1;
    chk(!mem_req && !cfg_we && !res_we && !done, "R1", "outputs active in reset",
        {mem_req, cfg_we, res_we, done}, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !cfg_we && !res_we && !done, "R1", "outputs active while idle",
        {mem_req, cfg_we, res_we, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sz[i] = 0;
    clear_mon();
    test_reset();
    run_case("mixed", 64, 8, 0, 16, 1, 32, 128, 4, 0, 0);
    run_case("stalls", 2, 0, 64, 0, 8, 16, 32, 1, 1, 0);
    run_case("all_empty", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_case("busy_start", 4, 4, 128, 0, 2, 1, 64, 8, 1, 1);
    run_case("rearm", 1, 1, 1, 1, 1, 1, 1, 1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule